// File: doc/BRIEF.md
# Asynchronous EPROM Word Read Controller

This block sits on the system clock and turns a one-cycle read request into a timed access of an asynchronous, byte-wide-free 16-bit read-only memory with an 18-bit word address and two active-low strobes: a chip select and an output gate. On acceptance it drives the address and lowers the chip select. It lowers the output gate only once the remaining slack allows, waits for the slowest of the three access paths, and captures the word. It releases the strobes in that same cycle and then holds itself busy while the memory may still be driving the shared data lines.

All timing is given in nanoseconds together with the clock period. Each delay becomes a cycle count at elaboration: the rounded-up quotient plus one margin cycle. This lets one netlist serve every speed grade from 55 ns to 150 ns. A parameter picks the idle policy between reads. The chip select either returns high (low-power standby) or stays low so that only the output gate toggles.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While reset is low and after it, `busy`=0, `rd_valid`=0, `mem_oe_n`=1, `mem_addr`=0 and `mem_ce_n` sits at its idle level (1 for standby policy, 0 for hold policy).
- R2: A clock edge with `rd_req`=1 and `busy`=0 accepts a read: after that edge `mem_addr` equals `rd_addr`, `mem_ce_n`=0 and `busy`=1. `mem_oe_n` is never 0 while `mem_ce_n` is 1.
- R3: With each delay converted as C(x) = ceil(x / CLK_NS) + 1, `mem_oe_n` falls exactly L = max(0, max(C(T_ACC), C(T_CE)) − C(T_OE)) cycles after the accepting edge.
- R4: The word on `mem_data` is captured T = L + C(T_OE) cycles after the accepting edge. `rd_valid` is 1 for exactly that one cycle and `rd_data` carries the captured word.
- R5: Both strobes are released (`mem_oe_n`=1, `mem_ce_n` to its idle level) on the capture edge. `mem_addr` holds its value from acceptance until the next accepted read.
- R6: `busy` stays 1 for C(T_DF) cycles after the capture edge and then drops. No read is accepted while `busy`=1.
- R7: `rd_req` and `rd_addr` presented while `busy`=1 have no effect: neither `mem_addr` nor the strobe timing changes. A request held high is taken at the first edge after `busy` falls.
- R8: With IDLE_STANDBY=0, `mem_ce_n` stays 0 at all times after reset, and only `mem_oe_n` toggles around each read.
- R9: Changing the nanosecond parameters (e.g. 150/150/50/35 ns at 4 ns clock) changes L, T and the float hold to the counts given by R3, R4 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken when `busy` is low |
| rd_addr | input | 18 | Word address of the request |
| busy | output | 1 | High from acceptance until float recovery ends |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 16 | Captured word |
| mem_addr | output | 18 | Address lines to the memory |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output gate |
| mem_data | input | 16 | Data lines from the memory |

## Verification
The hardest fault to expose is a capture that lands one cycle early, because a plain memory model would already show the right word. The bench memory therefore returns a junk pattern until each of the raw address, chip-select and output-gate delays has elapsed, counted from the moment each actually changed. Only a capture that honours all three sees the true word. The ignored-request case is reached by holding `rd_req` high across several reads while the address changes every cycle. A second instance with the hold policy and the slowest grade checks the idle level and the longer counts.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_LEAD,
      RD_ACCESS,
      RD_FLOAT
   } rd_state_e;

   // rounded-up cycle count plus one margin cycle
   function automatic int wait_cycles(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns + 1;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eprom_rd_timer.sv
module eprom_rd_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          last
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - TW'(1);
   end

   // a phase loaded with N ends on the N-th edge after loading
   assign last = (cnt == TW'(1));

   AST_TMR_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0)); // R3

endmodule

// File: rtl/eprom_rd_fsm.sv
module eprom_rd_fsm
   import eprom_rd_pkg::*;
#(
   parameter int   AW      = 18,
   parameter int   DW      = 16,
   parameter int   TW      = 4,
   parameter int   LEAD_C  = 9,
   parameter int   OE_C    = 6,
   parameter int   DF_C    = 6,
   parameter logic CE_IDLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] mem_data,
   input  logic          tmr_last,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          busy,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n
);

   rd_state_e state;

   assign busy = (state != RD_IDLE);

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state)
         RD_IDLE: if (rd_req) begin
            tmr_load = 1'b1;
            tmr_val  = (LEAD_C == 0) ? TW'(OE_C) : TW'(LEAD_C);
         end
         RD_LEAD: if (tmr_last) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(OE_C);
         end
         RD_ACCESS: if (tmr_last) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(DF_C);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         rd_valid <= 1'b0;
         rd_data  <= '0;
         mem_addr <= '0;
         mem_ce_n <= CE_IDLE;
         mem_oe_n <= 1'b1;
      end else begin
         rd_valid <= 1'b0;
         unique case (state)
            RD_IDLE: if (rd_req) begin
               mem_addr <= rd_addr;
               mem_ce_n <= 1'b0;
               if (LEAD_C == 0) begin
                  mem_oe_n <= 1'b0;
                  state    <= RD_ACCESS;
               end else begin
                  state    <= RD_LEAD;
               end
            end
            RD_LEAD: if (tmr_last) begin
               mem_oe_n <= 1'b0;
               state    <= RD_ACCESS;
            end
            RD_ACCESS: if (tmr_last) begin
               // sample and release on one edge: zero output hold
               rd_data  <= mem_data;
               rd_valid <= 1'b1;
               mem_oe_n <= 1'b1;
               mem_ce_n <= CE_IDLE;
               state    <= RD_FLOAT;
            end
            RD_FLOAT: if (tmr_last) state <= RD_IDLE;
            default: state <= RD_IDLE;
         endcase
      end
   end

   AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n); // R2
   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R4
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(mem_addr)); // R5
   AST_OE_RELEASE_AT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> rd_valid); // R5
   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy); // R6
   AST_FLOAT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RD_FLOAT && !tmr_last) |=> busy); // R6

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
   import eprom_rd_pkg::*;
#(
   parameter int AW           = 18,
   parameter int DW           = 16,
   parameter int CLK_NS       = 4,
   parameter int T_ACC_NS     = 55,
   parameter int T_CE_NS      = 55,
   parameter int T_OE_NS      = 20,
   parameter int T_DF_NS      = 20,
   parameter bit IDLE_STANDBY = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   output logic          busy,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   input  logic [DW-1:0] mem_data
);

   localparam int ACC_C    = wait_cycles(T_ACC_NS, CLK_NS);
   localparam int CE_C     = wait_cycles(T_CE_NS, CLK_NS);
   localparam int OE_C     = wait_cycles(T_OE_NS, CLK_NS);
   localparam int DF_C     = wait_cycles(T_DF_NS, CLK_NS);
   localparam int STROBE_C = max2(ACC_C, CE_C);
   localparam int LEAD_C   = (STROBE_C > OE_C) ? STROBE_C - OE_C : 0;
   localparam int MAX_C    = max2(max2(LEAD_C, OE_C), DF_C);
   localparam int TW       = $clog2(MAX_C + 1);

   initial begin
      assert (CLK_NS > 0) else $error("CLK_NS must be positive");
      assert (AW > 0 && DW > 0) else $error("bus widths must be positive");
      assert (T_ACC_NS >= 0 && T_CE_NS >= 0 && T_OE_NS >= 0 && T_DF_NS >= 0)
         else $error("delays must not be negative");
   end

   logic          tmr_load;
   logic [TW-1:0] tmr_val;
   logic          tmr_last;

   eprom_rd_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   if (IDLE_STANDBY) begin : g_standby
      eprom_rd_fsm #(
         .AW(AW), .DW(DW), .TW(TW), .LEAD_C(LEAD_C), .OE_C(OE_C),
         .DF_C(DF_C), .CE_IDLE(1'b1)
      ) u_fsm (
         .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
         .mem_data(mem_data), .tmr_last(tmr_last), .tmr_load(tmr_load),
         .tmr_val(tmr_val), .busy(busy), .rd_valid(rd_valid),
         .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
         .mem_oe_n(mem_oe_n)
      );
   end else begin : g_hold
      eprom_rd_fsm #(
         .AW(AW), .DW(DW), .TW(TW), .LEAD_C(LEAD_C), .OE_C(OE_C),
         .DF_C(DF_C), .CE_IDLE(1'b0)
      ) u_fsm (
         .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
         .mem_data(mem_data), .tmr_last(tmr_last), .tmr_load(tmr_load),
         .tmr_val(tmr_val), .busy(busy), .rd_valid(rd_valid),
         .rd_data(rd_data), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
         .mem_oe_n(mem_oe_n)
      );
   end

endmodule

// File: tb/tb_eprom_rd_ctrl.sv
module tb_eprom_mem #(
   parameter int RAW_A = 14,
   parameter int RAW_O = 5
) (
   input  logic        clk,
   input  logic [17:0] addr,
   input  logic        ce_n,
   input  logic        oe_n,
   output logic [15:0] data
);
   int aa = 0;
   int ca = -1;
   int oa = -1;
   logic [17:0] pa = '0;

   // ages counted in whole cycles since each input last changed
   always @(negedge clk) begin
      if (addr != pa) aa = 0; else if (aa < 100000) aa++;
      pa = addr;
      if (ce_n) ca = -1; else if (ca < 100000) ca++;
      if (oe_n) oa = -1; else if (oa < 100000) oa++;
   end

   assign data = (!ce_n && !oe_n && aa >= RAW_A && ca >= RAW_A && oa >= RAW_O)
                 ? (addr[15:0] ^ {addr[17:16], 14'h2A5A}) : 16'hDEAD;
endmodule

module tb_eprom_rd_ctrl;
   // expected cycle counts worked out from the requirements (4 ns clock)
   localparam int ACC_C = (55 + 3) / 4 + 1;      // 15
   localparam int OE_C  = (20 + 3) / 4 + 1;      // 6
   localparam int DF_C  = (20 + 3) / 4 + 1;      // 6
   localparam int LEAD  = ACC_C - OE_C;          // 9
   localparam int TCAP  = LEAD + OE_C;           // 15
   localparam int ACC2  = (150 + 3) / 4 + 1;     // 39
   localparam int OE2   = (50 + 3) / 4 + 1;      // 14
   localparam int DF2   = (35 + 3) / 4 + 1;      // 10
   localparam int LEAD2 = ACC2 - OE2;            // 25
   localparam int TCAP2 = LEAD2 + OE2;           // 39

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        req = 1'b0, req2 = 1'b0;
   logic [17:0] addr = '0, addr2 = '0;
   logic        busy, valid, ce_n, oe_n, busy2, valid2, ce_n2, oe_n2;
   logic [15:0] rdata, mdata, rdata2, mdata2;
   logic [17:0] maddr, maddr2;

   eprom_rd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rd_req(req), .rd_addr(addr), .busy(busy),
      .rd_valid(valid), .rd_data(rdata), .mem_addr(maddr), .mem_ce_n(ce_n),
      .mem_oe_n(oe_n), .mem_data(mdata)
   );
   tb_eprom_mem #(.RAW_A(14), .RAW_O(5)) u_mem (
      .clk(clk), .addr(maddr), .ce_n(ce_n), .oe_n(oe_n), .data(mdata)
   );

   eprom_rd_ctrl #(
      .T_ACC_NS(150), .T_CE_NS(150), .T_OE_NS(50), .T_DF_NS(35), .IDLE_STANDBY(1'b0)
   ) dut_hold (
      .clk(clk), .rst_n(rst_n), .rd_req(req2), .rd_addr(addr2), .busy(busy2),
      .rd_valid(valid2), .rd_data(rdata2), .mem_addr(maddr2), .mem_ce_n(ce_n2),
      .mem_oe_n(oe_n2), .mem_data(mdata2)
   );
   tb_eprom_mem #(.RAW_A(38), .RAW_O(13)) u_mem2 (
      .clk(clk), .addr(maddr2), .ce_n(ce_n2), .oe_n(oe_n2), .data(mdata2)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   function automatic logic [15:0] pat(input logic [17:0] a);
      return a[15:0] ^ {a[17:16], 14'h2A5A};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // behavioural reference for the standby instance: k = cycles since acceptance
   int k = -1;
   logic [17:0] la = '0;
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) k = -1;
      else if (k < 0) begin
         if (req) begin k = 0; la = addr; end   // R7: only taken when idle
      end else begin
         k++;
         if (k == TCAP + DF_C) k = -1;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk("R1", "busy", 32'(busy), 0);
         chk("R1", "valid", 32'(valid), 0);
         chk("R1", "oe_n", 32'(oe_n), 1);
         chk("R1", "ce_n", 32'(ce_n), 1);
         chk("R1", "addr", 32'(maddr), 0);
         chk("R1", "ce_n hold", 32'(ce_n2), 0);
      end else begin
         chk("R6", "busy", 32'(busy), 32'(k >= 0));
         chk("R2", "ce_n", 32'(ce_n), 32'(!(k >= 0 && k < TCAP)));
         chk("R3", "oe_n", 32'(oe_n), 32'(!(k >= LEAD && k < TCAP)));
         chk("R4", "valid", 32'(valid), 32'(k == TCAP));
         if (k == TCAP) chk("R4", "data", 32'(rdata), 32'(pat(la)));
         chk("R5", "addr", 32'(maddr), 32'(la));   // R7 shows here too
      end
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic issue(input logic [17:0] a);
      req = 1'b1;
      addr = a;
      @(negedge clk);
      while (!busy) @(negedge clk);
      req = 1'b0;
      addr = ~a;
      while (busy) @(negedge clk);
   endtask

   task automatic hold_read(input logic [17:0] a);
      @(negedge clk);
      req2 = 1'b1;
      addr2 = a;
      @(posedge clk);
      for (int j = 0; j <= TCAP2 + DF2 + 1; j++) begin
         @(negedge clk);
         if (j == 0) begin req2 = 1'b0; addr2 = 18'h15555; end
         chk("R8", "hold ce_n", 32'(ce_n2), 0);
         chk("R9", "hold oe_n", 32'(oe_n2), 32'(!(j >= LEAD2 && j < TCAP2)));
         chk("R9", "hold valid", 32'(valid2), 32'(j == TCAP2));
         chk("R9", "hold busy", 32'(busy2), 32'(j < TCAP2 + DF2));
         if (j == TCAP2) chk("R9", "hold data", 32'(rdata2), 32'(pat(a)));
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      issue(18'h00000);
      repeat (3) @(negedge clk);
      issue(18'h3FFFF);
      issue(18'h1234A);
      // R7: request held high while the address changes every cycle
      req = 1'b1;
      for (int i = 0; i < 70; i++) begin
         addr = 18'(i * 7919 + 5);
         @(negedge clk);
      end
      req = 1'b0;
      while (busy) @(negedge clk);
      for (int i = 0; i < 5; i++) issue(18'(i * 40503 + 77));
      hold_read(18'h2ABCD);
      hold_read(18'h00001);
      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule